// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between the decode stage and the data memory port of a 64-bit core. For each memory instruction it receives the 32-bit instruction word, the value of the base register and the value of the store source register. From these it derives the effective address, the access size, the byte lanes to touch and the store data. All of these are presented one clock after the request. The immediate is read from the load layout or the store layout, as the opcode directs. It is sign-extended to 64 bits and added to the base.

The data memory is organised in 8-byte rows. A 32-bit access therefore uses either the lower or the upper half of a row, chosen by address bit 2. When the memory returns a row for the single outstanding load, the unit picks the correct half and extends it by sign or by zero. A full row is passed through unchanged for the doubleword load. The result, with the destination register index, appears one clock after the response.

Supported encodings: opcode 0000011 is a load and opcode 0100011 is a store. funct3 010 selects a signed 32-bit load or a 32-bit store. funct3 110 selects an unsigned 32-bit load. funct3 011 selects a 64-bit load or store. No other combination starts an access.

Top module: `lsx_unit`

## Requirements
- R1: For a load, `mem_addr` equals `req_base` plus the 12-bit field in instruction bits 31:20, sign-extended from bit 11, with 64-bit wraparound addition.
- R2: For a store, the 12-bit offset is instruction bits 31:25 (upper seven bits) concatenated with bits 11:7 (lower five bits), sign-extended from bit 11 and added to `req_base` to form `mem_addr`.
- R3: `mem_ld_valid` rises one clock after an accepted request whose opcode is 0000011 and whose funct3 is 010, 110 or 011. `mem_st_valid` rises one clock after an accepted request whose opcode is 0100011 and whose funct3 is 010 or 011. Any other request, or no request, leaves both low, and the two are never high together.
- R4: `mem_dword` is 1 for funct3 011 and 0 for the 32-bit forms.
- R5: `mem_byte_en` is 0xFF for a 64-bit access. For a 32-bit access it is 0x0F when address bit 2 is 0 and 0xF0 when it is 1.
- R6: A 64-bit store puts all of `req_src` on `mem_wdata`. A 32-bit store puts `req_src[31:0]` in bits 31:0 (address bit 2 = 0) or bits 63:32 (address bit 2 = 1) and drives the other half to zero.
- R7: For a signed 32-bit load (funct3 010), `wb_data` is the selected half of `rsp_rdata` with its bit 31 replicated into bits 63:32.
- R8: For an unsigned 32-bit load (funct3 110), `wb_data` is the selected half with bits 63:32 zero.
- R9: For a 64-bit load (funct3 011), `wb_data` equals `rsp_rdata`.
- R10: `wb_valid` is high exactly one clock after `rsp_valid`, and `wb_rd` carries instruction bits 11:7 of the most recent load.
- R11: While `rst_n` is low, every output is driven to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_instr | input | 32 | Instruction word of the request |
| req_base | input | 64 | Base register value |
| req_src | input | 64 | Store source register value |
| mem_ld_valid | output | 1 | Registered load request to memory |
| mem_st_valid | output | 1 | Registered store request to memory |
| mem_addr | output | 64 | Effective byte address |
| mem_dword | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_byte_en | output | 8 | Byte lanes within the 8-byte row |
| mem_wdata | output | 64 | Store data placed in its lanes |
| rsp_valid | input | 1 | Memory returns the row for the outstanding load |
| rsp_rdata | input | 64 | Raw 8-byte row from memory |
| wb_valid | output | 1 | Register write value is valid |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Extended load result |

## Verification
The unit holds little state: the request registers, and the remembered load kind, lane and destination of the outstanding load. A fault in the request registers shows at the memory port on the very next clock, as a wrong address, lane mask or data half, or as a missing or spurious valid. A fault in the remembered load kind or lane stays hidden until the response comes back. It then shows one clock after `rsp_valid` as wrong upper bits or the wrong half in `wb_data`. The sweeps therefore cover every immediate value in both layouts, every opcode and funct3 pair, and every load kind in both lanes against data whose bit 31 and bit 63 differ.

// File: rtl/lsx_pkg.sv
// Shared encodings for the load/store address and extension unit.
// Assumes a 64-bit datapath and 32-bit instruction words.
package lsx_pkg;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_WORD   = 3'b010;
    localparam logic [2:0] F3_WORDU  = 3'b110;
    localparam logic [2:0] F3_DWORD  = 3'b011;
    localparam int         WORD_W    = 32;
    localparam int         WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        LK_WORD_S = 2'd0,
        LK_WORD_U = 2'd1,
        LK_DWORD  = 2'd2
    } ld_kind_e;
endpackage

// File: rtl/lsx_imm.sv
// Immediate builder: picks the load (contiguous) or store (split) layout
// and sign-extends the 12-bit value to the datapath width.
// Assumes a 32-bit instruction word; purely combinational.
module lsx_imm #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic [31:0]     instr,
    input  logic            store_fmt,
    output logic [XLEN-1:0] imm
);
    localparam int LO_W = 5;
    localparam int HI_W = IMM_W - LO_W;

    logic [HI_W-1:0]  hi_part;
    logic [LO_W-1:0]  lo_part;
    logic [IMM_W-1:0] raw;

    // Select the fields for the active layout and replicate the sign bit.
    always_comb begin
        hi_part = instr[31 -: HI_W];
        lo_part = store_fmt ? instr[11:7] : instr[24:20];
        raw     = {hi_part, lo_part};
        imm     = {{(XLEN-IMM_W){raw[IMM_W-1]}}, raw};
    end
endmodule

// File: rtl/lsx_agen.sv
// Address generator: adds base and offset, forms the lane mask and places
// store data in its half of the 8-byte row. Assumes naturally aligned accesses.
module lsx_agen #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   imm,
    input  logic              dword,
    input  logic [XLEN-1:0]   src,
    output logic [XLEN-1:0]   addr,
    output logic [XLEN/8-1:0] be,
    output logic [XLEN-1:0]   wdata
);
    import lsx_pkg::*;
    localparam int BYTES    = XLEN / 8;
    localparam int HALVES   = XLEN / WORD_W;
    localparam int LANE_BIT = $clog2(WORD_BYTES);
    localparam logic [BYTES-1:0] LO_MASK = {{(BYTES/2){1'b0}}, {(BYTES/2){1'b1}}};

    // Two's-complement effective address.
    assign addr = base + imm;

    // Lane mask for a full row or one half of it.
    always_comb begin
        if (dword)               be = '1;
        else if (addr[LANE_BIT]) be = ~LO_MASK;
        else                     be = LO_MASK;
    end

    // Store data per half: the whole source, or its low word in the addressed half.
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign wdata[g*WORD_W +: WORD_W] =
            dword                          ? src[g*WORD_W +: WORD_W] :
            (addr[LANE_BIT] == 1'(g))      ? src[WORD_W-1:0]         :
                                             '0;
    end
endmodule

// File: rtl/lsx_ldext.sv
// Load extender: takes the returned 8-byte row, selects the addressed half
// for 32-bit loads and extends it by sign or zero. Purely combinational.
module lsx_ldext #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  rdata,
    input  lsx_pkg::ld_kind_e kind,
    input  logic             hi,
    output logic [XLEN-1:0]  data
);
    import lsx_pkg::*;
    logic [WORD_W-1:0] word;

    // Pick the half, then extend according to the load kind.
    always_comb begin
        word = hi ? rdata[2*WORD_W-1:WORD_W] : rdata[WORD_W-1:0];
        unique case (kind)
            LK_DWORD:  data = rdata;
            LK_WORD_U: data = {{(XLEN-WORD_W){1'b0}}, word};
            default:   data = {{(XLEN-WORD_W){word[WORD_W-1]}}, word};
        endcase
    end
endmodule

// File: rtl/lsx_unit.sv
// Load/store address and extension unit. Decodes load/store encodings,
// registers the memory request one clock after the input, and registers the
// extended load result one clock after the memory response.
// Assumes at most one load outstanding and aligned addresses.
module lsx_unit #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_instr,
    input  logic [XLEN-1:0]   req_base,
    input  logic [XLEN-1:0]   req_src,
    output logic              mem_ld_valid,
    output logic              mem_st_valid,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_dword,
    output logic [XLEN/8-1:0] mem_byte_en,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              rsp_valid,
    input  logic [XLEN-1:0]   rsp_rdata,
    output logic              wb_valid,
    output logic [4:0]        wb_rd,
    output logic [XLEN-1:0]   wb_data
);
    import lsx_pkg::*;
    localparam int BYTES    = XLEN / 8;
    localparam int LANE_BIT = $clog2(WORD_BYTES);

    logic [6:0]        opc;
    logic [2:0]        f3;
    logic              is_ld, is_st, is_dw;
    ld_kind_e          kind_c;
    logic [XLEN-1:0]   imm_c, addr_c, wdata_c, ext_c;
    logic [BYTES-1:0]  be_c;
    ld_kind_e          pend_kind;
    logic              pend_hi;
    logic [4:0]        pend_rd;
    wire               unused_rs1 = ^req_instr[19:15];

    // Classify the request and the load kind.
    always_comb begin
        opc   = req_instr[6:0];
        f3    = req_instr[14:12];
        is_ld = (opc == OPC_LOAD) && (f3 == F3_WORD || f3 == F3_WORDU || f3 == F3_DWORD);
        is_st = (opc == OPC_STORE) && (f3 == F3_WORD || f3 == F3_DWORD);
        is_dw = (f3 == F3_DWORD);
        if (f3 == F3_DWORD)      kind_c = LK_DWORD;
        else if (f3 == F3_WORDU) kind_c = LK_WORD_U;
        else                     kind_c = LK_WORD_S;
    end

    lsx_imm #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
        .instr     (req_instr),
        .store_fmt (opc == OPC_STORE),
        .imm       (imm_c)
    );

    lsx_agen #(.XLEN(XLEN)) u_agen (
        .base  (req_base),
        .imm   (imm_c),
        .dword (is_dw),
        .src   (req_src),
        .addr  (addr_c),
        .be    (be_c),
        .wdata (wdata_c)
    );

    lsx_ldext #(.XLEN(XLEN)) u_ext (
        .rdata (rsp_rdata),
        .kind  (pend_kind),
        .hi    (pend_hi),
        .data  (ext_c)
    );

    // Request stage: register the memory request for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ld_valid <= 1'b0;
            mem_st_valid <= 1'b0;
            mem_addr     <= '0;
            mem_dword    <= 1'b0;
            mem_byte_en  <= '0;
            mem_wdata    <= '0;
        end else begin
            mem_ld_valid <= req_valid && is_ld;
            mem_st_valid <= req_valid && is_st;
            if (req_valid && (is_ld || is_st)) begin
                mem_addr    <= addr_c;
                mem_dword   <= is_dw;
                mem_byte_en <= be_c;
                mem_wdata   <= is_st ? wdata_c : '0;
            end
        end
    end

    // Remember kind, lane and destination of the outstanding load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_kind <= LK_WORD_S;
            pend_hi   <= 1'b0;
            pend_rd   <= '0;
        end else if (req_valid && is_ld) begin
            pend_kind <= kind_c;
            pend_hi   <= addr_c[LANE_BIT];
            pend_rd   <= req_instr[11:7];
        end
    end

    // Writeback stage: register the extended load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_rd    <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= rsp_valid;
            if (rsp_valid) begin
                wb_rd   <= pend_rd;
                wb_data <= ext_c;
            end
        end
    end
endmodule

// File: rtl/lsx_unit_chk.sv
// Checker for lsx_unit, attached by bind. Relates the registered outputs
// to the inputs of the previous clock.
module lsx_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_instr,
    input logic [63:0] req_base,
    input logic        mem_ld_valid,
    input logic        mem_st_valid,
    input logic [63:0] mem_addr,
    input logic        mem_dword,
    input logic [7:0]  mem_byte_en,
    input logic [63:0] mem_wdata,
    input logic        rsp_valid,
    input logic        wb_valid
);
    logic is_load_req;
    assign is_load_req = req_valid && req_instr[6:0] == 7'b0000011 &&
                         (req_instr[14:12] == 3'b010 || req_instr[14:12] == 3'b110 ||
                          req_instr[14:12] == 3'b011);

    AST_LD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        is_load_req |=> mem_addr == $past(req_base + {{52{req_instr[31]}}, req_instr[31:20]})); // R1
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_ld_valid && mem_st_valid)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mem_ld_valid && !mem_st_valid); // R3
    AST_LANE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ld_valid || mem_st_valid) |->
            (mem_dword ? mem_byte_en == 8'hFF
                       : (mem_byte_en == 8'h0F || mem_byte_en == 8'hF0))); // R5
    AST_ST_IDLE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_st_valid && !mem_dword) |->
            (mem_byte_en == 8'h0F ? mem_wdata[63:32] == 32'h0 : mem_wdata[31:0] == 32'h0)); // R6
    AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> wb_valid); // R10
    AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> !wb_valid); // R10
endmodule

bind lsx_unit lsx_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_instr    (req_instr),
    .req_base     (req_base),
    .mem_ld_valid (mem_ld_valid),
    .mem_st_valid (mem_st_valid),
    .mem_addr     (mem_addr),
    .mem_dword    (mem_dword),
    .mem_byte_en  (mem_byte_en),
    .mem_wdata    (mem_wdata),
    .rsp_valid    (rsp_valid),
    .wb_valid     (wb_valid)
);

// File: tb/lsx_unit_tb.sv
// Sweeping testbench for lsx_unit: every immediate in both layouts, every
// opcode/funct3 pair, and every load kind in both lanes.
module lsx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_instr = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_src = '0;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_rdata = '0;
    logic        mem_ld_valid, mem_st_valid, mem_dword, wb_valid;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic [7:0]  mem_byte_en;
    logic [4:0]  wb_rd;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    lsx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_instr(req_instr),
        .req_base(req_base), .req_src(req_src), .mem_ld_valid(mem_ld_valid),
        .mem_st_valid(mem_st_valid), .mem_addr(mem_addr), .mem_dword(mem_dword),
        .mem_byte_en(mem_byte_en), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sx12(input logic [11:0] v);
        return {{52{v[11]}}, v};
    endfunction

    // Present one request for a clock, then stop at the next falling edge.
    task automatic issue(input logic [31:0] ins, input logic [63:0] b, input logic [63:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_instr = ins; req_base = b; req_src = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] ld_ins(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
        return {imm, 5'd2, f3, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] st_ins(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd9, 5'd2, f3, imm[4:0], 7'b0100011};
    endfunction

    // Run one load through request and response; check writeback.
    task automatic load_rt(input logic [2:0] f3, input logic hi, input logic [63:0] row,
                           input logic [4:0] rd, input string req);
        logic [31:0] w;
        logic [63:0] exp;
        issue(ld_ins({9'd0, hi, 2'b00}, f3, rd), 64'h1000, 64'h0);
        rsp_valid = 1'b1; rsp_rdata = row;
        @(negedge clk);
        rsp_valid = 1'b0;
        w = hi ? row[63:32] : row[31:0];
        if (f3 == 3'b011)      exp = row;
        else if (f3 == 3'b110) exp = {32'h0, w};
        else                   exp = {{32{w[31]}}, w};
        chk({req, " wb_data"}, wb_data, exp);
        chk("R10 wb_valid", {63'd0, wb_valid}, 64'd1);
        chk("R10 wb_rd", {59'd0, wb_rd}, {59'd0, rd});
        @(negedge clk);
        chk("R10 wb_valid drops", {63'd0, wb_valid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] bases [3];
        logic [63:0] rows [5];
        bases[0] = 64'h0; bases[1] = 64'h0000_0000_0001_0000; bases[2] = 64'hFFFF_FFFF_FFFF_FFF0;
        rows[0] = 64'h8000_0000_7FFF_FFFF; rows[1] = 64'h7FFF_FFFF_8000_0000;
        rows[2] = 64'hFFFF_FFFF_FFFF_FFFF; rows[3] = 64'h0123_4567_89AB_CDEF;
        rows[4] = 64'h0;

        req_valid = 1'b1; req_instr = ld_ins(12'h004, 3'b011, 5'd3); rsp_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R11: outputs held at zero under reset
        chk("R11 mem_ld_valid", {63'd0, mem_ld_valid}, 64'd0);
        chk("R11 mem_addr", mem_addr, 64'd0);
        chk("R11 mem_byte_en", {56'd0, mem_byte_en}, 64'd0);
        chk("R11 wb_valid", {63'd0, wb_valid}, 64'd0);
        chk("R11 wb_data", wb_data, 64'd0);
        req_valid = 1'b0; rsp_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R4, R5: all load immediates over several bases and both sizes
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 4096; i++) begin
                logic [63:0] ea;
                logic [2:0]  f3;
                f3 = (i % 3 == 0) ? 3'b011 : ((i % 3 == 1) ? 3'b010 : 3'b110);
                ea = bases[b] + sx12(12'(i));
                issue(ld_ins(12'(i), f3, 5'(i)), bases[b], 64'hDEAD_BEEF_CAFE_F00D);
                chk("R1 load addr", mem_addr, ea);
                chk("R3 load valid", {62'd0, mem_ld_valid, mem_st_valid}, 64'd2);
                chk("R4 load size", {63'd0, mem_dword}, {63'd0, f3 == 3'b011});
                chk("R5 load lanes", {56'd0, mem_byte_en},
                    {56'd0, (f3 == 3'b011) ? 8'hFF : (ea[2] ? 8'hF0 : 8'h0F)});
            end
        end

        // R2, R5, R6: all store immediates, both sizes
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 4096; i++) begin
                logic [63:0] ea, src, wd;
                logic dw;
                dw  = i[0];
                src = {32'h8765_4321, 20'h0, 12'(i)} ^ {bases[b][31:0], 32'h5A5A_A5A5};
                ea  = bases[b] + sx12(12'(i));
                if (dw)         wd = src;
                else if (ea[2]) wd = {src[31:0], 32'h0};
                else            wd = {32'h0, src[31:0]};
                issue(st_ins(12'(i), dw ? 3'b011 : 3'b010), bases[b], src);
                chk("R2 store addr", mem_addr, ea);
                chk("R3 store valid", {62'd0, mem_ld_valid, mem_st_valid}, 64'd1);
                chk("R4 store size", {63'd0, mem_dword}, {63'd0, dw});
                chk("R5 store lanes", {56'd0, mem_byte_en},
                    {56'd0, dw ? 8'hFF : (ea[2] ? 8'hF0 : 8'h0F)});
                chk("R6 store data", mem_wdata, wd);
            end
        end

        // R3: every opcode and funct3 pair
        for (int op = 0; op < 128; op++) begin
            for (int f = 0; f < 8; f++) begin
                logic el, es;
                el = (op == 7'b0000011) && (f == 2 || f == 6 || f == 3);
                es = (op == 7'b0100011) && (f == 2 || f == 3);
                issue({12'h010, 5'd1, 3'(f), 5'd4, 7'(op)}, 64'h40, 64'h1);
                chk("R3 decode", {62'd0, mem_ld_valid, mem_st_valid}, {62'd0, el, es});
            end
        end
        // R3: no request, no access
        @(negedge clk);
        req_instr = ld_ins(12'h0, 3'b011, 5'd1);
        @(negedge clk);
        chk("R3 idle", {62'd0, mem_ld_valid, mem_st_valid}, 64'd0);

        // R7, R8, R9, R10: every load kind, both halves, several rows
        for (int r = 0; r < 5; r++) begin
            for (int h = 0; h < 2; h++) begin
                load_rt(3'b010, h[0], rows[r], 5'(7 + r), "R7 signed word");
                load_rt(3'b110, h[0], rows[r], 5'(17 + r), "R8 unsigned word");
            end
            load_rt(3'b011, 1'b0, rows[r], 5'(27 + r), "R9 dword");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule